// File: doc/BRIEF.md
# NAND Flash Command Front End

This block is the device side of a small-page, byte-wide NAND flash model. It watches one I/O byte together with the chip-enable, command-latch and address-latch pins. Each write strobe is sorted into a command, an address byte or a data byte. The block decodes the opcode and collects address bytes, lowest first. It then decides when a page load, a page program, a block erase, an identification read or a status read begins.

Page-level work goes to a separate array block through a request that stays high until the array pulses done. The request carries an operation code, a page number and a column. Read data comes back from that array one byte at a time: the front end presents a column, the array returns the byte at that column, and each read strobe steps the column. Program data bytes are passed on one at a time, each with its index in the page buffer. The identification bytes and the status byte are produced locally. The ready/busy output is tied to ready.

Top module: `nfc_cmd_frontend`

## Requirements
- R1: A write strobe (io_wr) is used only while ce_n is low, and the same holds for a read strobe (io_rd). While ce_n is high, io_dout is 0x00 and strobes change nothing. A strobe with cle high is a command. With cle low and ale high it is an address byte. With both low it is a data byte.
- R2: Address bytes fill the address register lowest byte first, and at most three are taken. Byte 0 is the column, and bytes 1 and 2 form page bits 7:0 and 15:8. Every recognised command byte clears the address-byte count but leaves the address register as it is.
- R3: Opcodes 0x00, 0x01 and 0x50 all select the read command, with a column offset of 0, 0x100 and PAGE_BYTES (512) respectively. The offset is added to the column of the next load or program request that is actually issued, and it returns to 0 once used. A program setup (0x80) leaves a pending offset in place.
- R4: In the read command, the third address byte issues a load request (arr_op = 1). Its page is address bytes 1 and 2, and its column is byte 0 plus the offset.
- R5: Once a load completes, io_dout equals arr_rdata at column arr_rcol. The column starts at the request column and each read strobe adds one, for a total of (PAGE_BYTES + SPARE_BYTES) minus the start column bytes. After that, and when the start column is at or past 528, io_dout is 0x00.
- R6: Read ID (0x90) followed by one address byte returns 0xEC, 0x73, 0xA5 and 0xC0 on successive reads, then 0x00.
- R7: Read status (0x70) makes every following read return the status byte until the next command. The status byte has bit 7 equal to the live wp_n level, bit 6 set (ready) and bit 0 clear (error), so it reads 0xC0 when unprotected and 0x40 when protected.
- R8: After program setup (0x80) and three address bytes, each data byte appears on wr_valid/wr_data with wr_idx counting up from 0. Bytes beyond index 527 are dropped. Program confirm (0x10) issues arr_op = 2, with the page taken from address bytes 1 and 2 and the column from byte 0 plus the offset.
- R9: Erase confirm (0xD0) issues arr_op = 3. Its page is the address bytes received since the last command, with any byte not received counted as zero.
- R10: While wp_n is low, program confirm and erase confirm issue no request.
- R11: The rst input and the reset opcode (0xFF) both return the block to the read command and clear the address, the byte count, the read length and the offset, so that the next read returns 0x00.
- R12: An unrecognised opcode changes nothing. The output mode and the address-byte count are both kept.
- R13: ready_busy is always 1. arr_req, arr_op, arr_page and arr_col stay unchanged until arr_done, and only one request is outstanding: a trigger that arrives while a request is pending is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| wp_n | input | 1 | Write protect, active low |
| io_wr | input | 1 | One-cycle write strobe for io_din |
| io_din | input | 8 | Byte written by the host |
| io_rd | input | 1 | One-cycle read strobe that steps the output |
| io_dout | output | 8 | Byte presented to the host |
| ready_busy | output | 1 | Ready/busy, always ready |
| arr_req | output | 1 | Array request, held until done |
| arr_op | output | 2 | 1 load, 2 program, 3 erase |
| arr_page | output | 16 | Page number of the request |
| arr_col | output | 11 | Start column of the request |
| arr_done | input | 1 | Array completion pulse |
| arr_rcol | output | 11 | Column currently being read |
| arr_rdata | input | 8 | Array byte at arr_rcol |
| wr_valid | output | 1 | Program data byte valid |
| wr_data | output | 8 | Program data byte |
| wr_idx | output | 11 | Index of the data byte in the buffer |

## Verification
Two states are hard to reach from the ports. The first is the end of a page read, where the output must switch to zero after exactly the right number of strobes. The spare-area opcode with a column byte of 0x0C starts the read four bytes before the end, so the cut-off comes after a few strobes rather than hundreds. The second is a confirm that arrives while the array is still busy. The bench's array stub answers after several cycles, and two erase confirms are sent back to back so the second lands inside that window. A third sequence puts an unknown opcode between address bytes to show that the byte count survives it.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam int TRIG_BYTES = 3;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_ID,
        CMD_STAT,
        CMD_PSET,
        CMD_PCONF,
        CMD_ESET,
        CMD_ECONF,
        CMD_RESET
    } nfc_cmd_e;

    typedef enum logic [1:0] {
        OUT_NONE,
        OUT_ID,
        OUT_STAT,
        OUT_PAGE
    } nfc_out_e;

    typedef enum logic [1:0] {
        AOP_NONE  = 2'd0,
        AOP_LOAD  = 2'd1,
        AOP_PROG  = 2'd2,
        AOP_ERASE = 2'd3
    } nfc_aop_e;

    typedef struct packed {
        logic is_cmd;
        logic is_addr;
        logic is_data;
    } nfc_cls_t;

    typedef struct packed {
        logic     known;
        nfc_cmd_e cmd;
        logic     set_off;
        logic [1:0] off_sel;
    } nfc_dec_t;

    function automatic nfc_dec_t nfc_decode_op(input logic [7:0] b);
        nfc_dec_t d;
        d.known   = 1'b1;
        d.cmd     = CMD_READ;
        d.set_off = 1'b0;
        d.off_sel = 2'd0;
        case (b)
            8'h00: begin d.set_off = 1'b1; d.off_sel = 2'd0; end
            8'h01: begin d.set_off = 1'b1; d.off_sel = 2'd1; end
            8'h50: begin d.set_off = 1'b1; d.off_sel = 2'd2; end
            8'h90: d.cmd = CMD_ID;
            8'h70: d.cmd = CMD_STAT;
            8'h80: d.cmd = CMD_PSET;
            8'h10: d.cmd = CMD_PCONF;
            8'h60: d.cmd = CMD_ESET;
            8'hD0: d.cmd = CMD_ECONF;
            8'hFF: d.cmd = CMD_RESET;
            default: d.known = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic [7:0] nfc_status(input logic wp_n);
        return {wp_n, 1'b1, 6'b000000};
    endfunction

endpackage

// File: rtl/nfc_byte_decode.sv
module nfc_byte_decode
    import nfc_pkg::*;
#(
    parameter int PAGE_BYTES = 512,
    parameter int COL_W      = 11
) (
    input  logic             ce_n,
    input  logic             cle,
    input  logic             ale,
    input  logic             io_wr,
    input  logic [7:0]       io_din,
    output nfc_cls_t         cls,
    output nfc_dec_t         dec,
    output logic [COL_W-1:0] off_val
);
    logic active;

    assign active = io_wr && !ce_n;

    always_comb begin
        cls.is_cmd  = active && cle;
        cls.is_addr = active && !cle && ale;
        cls.is_data = active && !cle && !ale;
    end

    assign dec = nfc_decode_op(io_din);

    always_comb begin
        case (dec.off_sel)
            2'd1:    off_val = COL_W'(256);
            2'd2:    off_val = COL_W'(PAGE_BYTES);
            default: off_val = '0;
        endcase
    end
endmodule

// File: rtl/nfc_addr_asm.sv
module nfc_addr_asm #(
    parameter int ADDR_BYTES = 3,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              zero,
    input  logic              take_en,
    input  logic [7:0]        din,
    output logic              take,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_d,
    output logic [ADDR_W-1:0] addr_d,
    output logic [ADDR_W-1:0] addr_masked
);
    logic [ADDR_W-1:0] addr_q;

    assign take  = take_en && (cnt_q < CNT_W'(ADDR_BYTES));
    assign cnt_d = take ? cnt_q + 1'b1 : cnt_q;

    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_lane
        assign addr_d[8*i +: 8] = (take && cnt_q == CNT_W'(i)) ? din : addr_q[8*i +: 8];
        assign addr_masked[8*i +: 8] = (CNT_W'(i) < cnt_q) ? addr_q[8*i +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst || zero) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (take) begin
            addr_q <= addr_d;
            cnt_q  <= cnt_d;
        end
    end
endmodule

// File: rtl/nfc_out_mux.sv
module nfc_out_mux
    import nfc_pkg::*;
#(
    parameter logic [7:0] MFR_ID  = 8'hEC,
    parameter logic [7:0] DEV_ID  = 8'h73,
    parameter logic [7:0] FILL_ID = 8'hA5,
    parameter logic [7:0] TAIL_ID = 8'hC0
) (
    input  logic       ce_n,
    input  logic       wp_n,
    input  nfc_out_e   mode,
    input  logic [2:0] id_idx,
    input  logic       page_ok,
    input  logic [7:0] arr_rdata,
    output logic [7:0] io_dout
);
    logic [7:0] id_byte;

    always_comb begin
        case (id_idx)
            3'd0:    id_byte = MFR_ID;
            3'd1:    id_byte = DEV_ID;
            3'd2:    id_byte = FILL_ID;
            3'd3:    id_byte = TAIL_ID;
            default: id_byte = 8'h00;
        endcase
    end

    always_comb begin
        if (ce_n) begin
            io_dout = 8'h00;
        end else begin
            case (mode)
                OUT_ID:   io_dout = id_byte;
                OUT_STAT: io_dout = nfc_status(wp_n);
                OUT_PAGE: io_dout = page_ok ? arr_rdata : 8'h00;
                default:  io_dout = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/nfc_cmd_frontend.sv
module nfc_cmd_frontend
    import nfc_pkg::*;
#(
    parameter int         PAGE_BYTES  = 512,
    parameter int         SPARE_BYTES = 16,
    parameter int         ADDR_BYTES  = 3,
    parameter logic [7:0] MFR_ID      = 8'hEC,
    parameter logic [7:0] DEV_ID      = 8'h73,
    parameter logic [7:0] FILL_ID     = 8'hA5,
    localparam int TOTAL  = PAGE_BYTES + SPARE_BYTES,
    localparam int COL_W  = $clog2(2 * PAGE_BYTES + 256),
    localparam int ADDR_W = 8 * ADDR_BYTES,
    localparam int PAGE_W = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              cle,
    input  logic              ale,
    input  logic              wp_n,
    input  logic              io_wr,
    input  logic [7:0]        io_din,
    input  logic              io_rd,
    output logic [7:0]        io_dout,
    output logic              ready_busy,
    output logic              arr_req,
    output logic [1:0]        arr_op,
    output logic [PAGE_W-1:0] arr_page,
    output logic [COL_W-1:0]  arr_col,
    input  logic              arr_done,
    output logic [COL_W-1:0]  arr_rcol,
    input  logic [7:0]        arr_rdata,
    output logic              wr_valid,
    output logic [7:0]        wr_data,
    output logic [COL_W-1:0]  wr_idx
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);

    nfc_cls_t          cls;
    nfc_dec_t          dec;
    logic [COL_W-1:0]  off_val;
    logic              take;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] addr_d, addr_masked;
    logic              cmd_ok, cmd_reset;

    nfc_cmd_e          cur_q;
    nfc_out_e          mode_q;
    logic [2:0]        id_idx_q;
    logic [COL_W-1:0]  col_off_q;
    logic [COL_W-1:0]  rd_col_q, rd_len_q;
    logic              loaded_q;
    logic              req_q;
    nfc_aop_e          aop_q;
    logic [PAGE_W-1:0] page_q;
    logic [COL_W-1:0]  col_q;
    logic [COL_W-1:0]  wcnt_q;
    logic              wv_q;
    logic [7:0]        wd_q;
    logic [COL_W-1:0]  wi_q;

    logic [COL_W-1:0]  req_col;
    logic [COL_W-1:0]  req_len;
    logic              rd_fire;
    logic              page_ok;

    nfc_byte_decode #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) u_dec (
        .ce_n(ce_n), .cle(cle), .ale(ale), .io_wr(io_wr), .io_din(io_din),
        .cls(cls), .dec(dec), .off_val(off_val)
    );

    assign cmd_ok    = cls.is_cmd && dec.known;
    assign cmd_reset = cmd_ok && dec.cmd == CMD_RESET;

    nfc_addr_asm #(.ADDR_BYTES(ADDR_BYTES)) u_addr (
        .clk(clk), .rst(rst), .clr(cmd_ok), .zero(cmd_reset),
        .take_en(cls.is_addr), .din(io_din), .take(take),
        .cnt_q(cnt_q), .cnt_d(cnt_d), .addr_d(addr_d), .addr_masked(addr_masked)
    );

    assign req_col = COL_W'(addr_d[7:0]) + col_off_q;
    assign req_len = (req_col < COL_W'(TOTAL)) ? COL_W'(TOTAL) - req_col : '0;
    assign rd_fire = io_rd && !ce_n;
    assign page_ok = loaded_q && (rd_len_q != '0);

    nfc_out_mux #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .FILL_ID(FILL_ID)) u_out (
        .ce_n(ce_n), .wp_n(wp_n), .mode(mode_q), .id_idx(id_idx_q),
        .page_ok(page_ok), .arr_rdata(arr_rdata), .io_dout(io_dout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= CMD_READ;
            mode_q    <= OUT_PAGE;
            id_idx_q  <= '0;
            col_off_q <= '0;
            rd_col_q  <= '0;
            rd_len_q  <= '0;
            loaded_q  <= 1'b0;
            req_q     <= 1'b0;
            aop_q     <= AOP_NONE;
            page_q    <= '0;
            col_q     <= '0;
            wcnt_q    <= '0;
            wv_q      <= 1'b0;
            wd_q      <= '0;
            wi_q      <= '0;
        end else begin
            wv_q <= 1'b0;

            if (req_q && arr_done) begin
                req_q <= 1'b0;
                if (aop_q == AOP_LOAD) loaded_q <= 1'b1;
            end

            if (rd_fire) begin
                if (mode_q == OUT_ID && id_idx_q < 3'd4) begin
                    id_idx_q <= id_idx_q + 3'd1;
                end else if (mode_q == OUT_PAGE && page_ok) begin
                    rd_col_q <= rd_col_q + 1'b1;
                    rd_len_q <= rd_len_q - 1'b1;
                end
            end

            if (cmd_ok) begin
                case (dec.cmd)
                    CMD_READ: begin
                        cur_q     <= CMD_READ;
                        mode_q    <= OUT_PAGE;
                        rd_len_q  <= '0;
                        loaded_q  <= 1'b0;
                        col_off_q <= off_val;
                    end
                    CMD_RESET: begin
                        cur_q     <= CMD_READ;
                        mode_q    <= OUT_PAGE;
                        rd_len_q  <= '0;
                        loaded_q  <= 1'b0;
                        col_off_q <= '0;
                    end
                    CMD_STAT: begin
                        cur_q  <= CMD_STAT;
                        mode_q <= OUT_STAT;
                    end
                    CMD_PSET: begin
                        cur_q  <= CMD_PSET;
                        mode_q <= OUT_NONE;
                        wcnt_q <= '0;
                    end
                    CMD_PCONF: begin
                        cur_q  <= CMD_PCONF;
                        mode_q <= OUT_NONE;
                        if (wp_n && !req_q) begin
                            req_q     <= 1'b1;
                            aop_q     <= AOP_PROG;
                            page_q    <= addr_d[ADDR_W-1 -: PAGE_W];
                            col_q     <= req_col;
                            col_off_q <= '0;
                        end
                    end
                    CMD_ECONF: begin
                        cur_q  <= CMD_ECONF;
                        mode_q <= OUT_NONE;
                        if (wp_n && !req_q) begin
                            req_q  <= 1'b1;
                            aop_q  <= AOP_ERASE;
                            page_q <= addr_masked[PAGE_W-1:0];
                            col_q  <= '0;
                        end
                    end
                    default: begin
                        cur_q  <= dec.cmd;
                        mode_q <= OUT_NONE;
                    end
                endcase
            end

            if (take) begin
                if (cnt_d == CNT_W'(1) && cur_q == CMD_ID) begin
                    mode_q   <= OUT_ID;
                    id_idx_q <= '0;
                end
                if (cnt_d == CNT_W'(TRIG_BYTES) && cur_q == CMD_READ && !req_q) begin
                    req_q     <= 1'b1;
                    aop_q     <= AOP_LOAD;
                    page_q    <= addr_d[ADDR_W-1 -: PAGE_W];
                    col_q     <= req_col;
                    col_off_q <= '0;
                    rd_col_q  <= req_col;
                    rd_len_q  <= req_len;
                    loaded_q  <= 1'b0;
                    mode_q    <= OUT_PAGE;
                end
            end

            if (cls.is_data && cur_q == CMD_PSET && cnt_q >= CNT_W'(TRIG_BYTES)
                && wcnt_q < COL_W'(TOTAL)) begin
                wv_q   <= 1'b1;
                wd_q   <= io_din;
                wi_q   <= wcnt_q;
                wcnt_q <= wcnt_q + 1'b1;
            end
        end
    end

    assign ready_busy = 1'b1;
    assign arr_req    = req_q;
    assign arr_op     = aop_q;
    assign arr_page   = page_q;
    assign arr_col    = col_q;
    assign arr_rcol   = rd_col_q;
    assign wr_valid   = wv_q;
    assign wr_data    = wd_q;
    assign wr_idx     = wi_q;
endmodule

// File: rtl/nfc_cmd_frontend_chk.sv
module nfc_cmd_frontend_chk #(
    parameter int PAGE_W = 16,
    parameter int COL_W  = 11,
    parameter int TOTAL  = 528
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              wp_n,
    input logic              arr_req,
    input logic [1:0]        arr_op,
    input logic [PAGE_W-1:0] arr_page,
    input logic [COL_W-1:0]  arr_col,
    input logic              arr_done,
    input logic [COL_W-1:0]  arr_rcol,
    input logic              wr_valid,
    input logic [COL_W-1:0]  wr_idx
);
    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_req && !arr_done) |=> (arr_req && $stable(arr_op) && $stable(arr_page) && $stable(arr_col)));

    // R10
    wp_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(arr_req) && arr_op != 2'd1) |-> $past(wp_n));

    // R8
    wr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_idx < COL_W'(TOTAL)));

    // R4
    load_col_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(arr_req) && arr_op == 2'd1) |-> (arr_col == arr_rcol));

    // R1
    ce_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n && !arr_done) |=> $stable(arr_req));

    // R5
    rcol_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$rose(arr_req) && arr_rcol != $past(arr_rcol)) |-> (arr_rcol == $past(arr_rcol) + 1'b1));
endmodule

bind nfc_cmd_frontend nfc_cmd_frontend_chk #(.PAGE_W(PAGE_W), .COL_W(COL_W), .TOTAL(TOTAL)) u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .wp_n(wp_n), .arr_req(arr_req), .arr_op(arr_op),
    .arr_page(arr_page), .arr_col(arr_col), .arr_done(arr_done), .arr_rcol(arr_rcol),
    .wr_valid(wr_valid), .wr_idx(wr_idx)
);

// File: tb/nfc_cmd_frontend_tb.sv
module nfc_cmd_frontend_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        ce_n = 1, cle = 0, ale = 0, wp_n = 1;
    logic        io_wr = 0, io_rd = 0;
    logic [7:0]  io_din = 0;
    logic [7:0]  io_dout;
    logic        ready_busy;
    logic        arr_req;
    logic [1:0]  arr_op;
    logic [15:0] arr_page;
    logic [10:0] arr_col;
    logic        arr_done;
    logic [10:0] arr_rcol;
    logic [7:0]  arr_rdata;
    logic        wr_valid;
    logic [7:0]  wr_data;
    logic [10:0] wr_idx;

    int total = 0, bad = 0;
    string cur_req = "R11";
    int req_count = 0, wv_count = 0;
    logic prev_req = 0;
    logic [2:0] lat;

    always #10 clk = ~clk;

    nfc_cmd_frontend u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
        .io_wr(io_wr), .io_din(io_din), .io_rd(io_rd), .io_dout(io_dout),
        .ready_busy(ready_busy), .arr_req(arr_req), .arr_op(arr_op),
        .arr_page(arr_page), .arr_col(arr_col), .arr_done(arr_done),
        .arr_rcol(arr_rcol), .arr_rdata(arr_rdata), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_idx(wr_idx)
    );

    // array stub: answers after a few cycles, data = column xor page
    assign arr_rdata = arr_rcol[7:0] ^ arr_page[7:0];
    always @(posedge clk) begin
        if (rst) begin
            arr_done <= 1'b0;
            lat      <= '0;
        end else begin
            arr_done <= 1'b0;
            if (arr_req && !arr_done) begin
                if (lat == 3'd2) begin arr_done <= 1'b1; lat <= '0; end
                else lat <= lat + 3'd1;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    localparam int TOT = 528;
    localparam int M_READ = 0, M_ID = 1, M_STAT = 2, M_PSET = 3, M_PCONF = 4, M_ESET = 5, M_ECONF = 6;
    localparam int O_NONE = 0, O_ID = 1, O_STAT = 2, O_PAGE = 3;
    int m_cur = 0, m_mode = O_PAGE, m_idx = 0, m_off = 0, m_addr = 0, m_cnt = 0;
    int m_col = 0, m_len = 0, m_loaded = 0, m_pend = 0, m_op = 0, m_page = 0, m_rcol_req = 0;
    int m_wcnt = 0, m_wv = 0, m_wd = 0, m_wi = 0;

    task automatic m_issue(input int op, input int page, input int col);
        m_pend = 1; m_op = op; m_page = page; m_rcol_req = col;
    endtask

    task automatic model_cmd(input int b);
        case (b)
            8'h00, 8'h01, 8'h50: begin
                m_cur = M_READ; m_mode = O_PAGE; m_len = 0; m_loaded = 0;
                m_off = (b == 8'h01) ? 256 : (b == 8'h50) ? 512 : 0;
                m_cnt = 0;
            end
            8'hFF: begin
                m_cur = M_READ; m_mode = O_PAGE; m_len = 0; m_loaded = 0;
                m_off = 0; m_cnt = 0; m_addr = 0;
            end
            8'h70: begin m_cur = M_STAT; m_mode = O_STAT; m_cnt = 0; end
            8'h90: begin m_cur = M_ID; m_mode = O_NONE; m_cnt = 0; end
            8'h80: begin m_cur = M_PSET; m_mode = O_NONE; m_wcnt = 0; m_cnt = 0; end
            8'h60: begin m_cur = M_ESET; m_mode = O_NONE; m_cnt = 0; end
            8'h10: begin
                m_cur = M_PCONF; m_mode = O_NONE;
                if (wp_n && m_pend == 0) begin
                    m_issue(2, (m_addr >> 8) & 16'hFFFF, (m_addr & 255) + m_off);
                    m_off = 0;
                end
                m_cnt = 0;
            end
            8'hD0: begin
                m_cur = M_ECONF; m_mode = O_NONE;
                if (wp_n && m_pend == 0)
                    m_issue(3, (m_addr & ((1 << (8 * m_cnt)) - 1)) & 16'hFFFF, 0);
                m_cnt = 0;
            end
            default: ;
        endcase
    endtask

    task automatic model_addr(input int b);
        int c;
        if (m_cnt < 3) begin
            m_addr = (m_addr & ~(255 << (8 * m_cnt))) | (b << (8 * m_cnt));
            m_cnt++;
            if (m_cnt == 1 && m_cur == M_ID) begin m_mode = O_ID; m_idx = 0; end
            if (m_cnt == 3 && m_cur == M_READ && m_pend == 0) begin
                c = (m_addr & 255) + m_off;
                m_issue(1, (m_addr >> 8) & 16'hFFFF, c);
                m_off = 0; m_col = c; m_len = (c < TOT) ? TOT - c : 0;
                m_loaded = 0; m_mode = O_PAGE;
            end
        end
    endtask

    always @(posedge clk) begin
        m_wv = 0;
        if (rst) begin
            m_cur = M_READ; m_mode = O_PAGE; m_idx = 0; m_off = 0; m_addr = 0; m_cnt = 0;
            m_col = 0; m_len = 0; m_loaded = 0; m_pend = 0; m_op = 0; m_page = 0;
            m_rcol_req = 0; m_wcnt = 0; m_wd = 0; m_wi = 0;
        end else begin
            if (m_pend != 0 && arr_done) begin
                m_pend = 0;
                if (m_op == 1) m_loaded = 1;
            end
            if (io_rd && !ce_n) begin
                if (m_mode == O_ID && m_idx < 4) m_idx++;
                else if (m_mode == O_PAGE && m_loaded != 0 && m_len > 0) begin m_col++; m_len--; end
            end
            if (io_wr && !ce_n) begin
                if (cle) model_cmd(io_din);
                else if (ale) model_addr(io_din);
                else if (m_cur == M_PSET && m_cnt >= 3 && m_wcnt < TOT) begin
                    m_wv = 1; m_wd = io_din; m_wi = m_wcnt; m_wcnt++;
                end
            end
        end
    end

    function automatic int m_dout();
        if (ce_n) return 0;
        case (m_mode)
            O_ID:   return (m_idx == 0) ? 8'hEC : (m_idx == 1) ? 8'h73 : (m_idx == 2) ? 8'hA5 : (m_idx == 3) ? 8'hC0 : 0;
            O_STAT: return wp_n ? 8'hC0 : 8'h40;
            O_PAGE: return (m_loaded != 0 && m_len > 0) ? ((m_col ^ m_page) & 255) : 0;
            default: return 0;
        endcase
    endfunction

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check({cur_req, " dout"}, io_dout, m_dout());
            check("R13 ready", ready_busy, 1);
            check({cur_req, " req"}, arr_req, m_pend);
            if (m_pend != 0) begin
                check({cur_req, " op"}, arr_op, m_op);
                check({cur_req, " page"}, arr_page, m_page);
                check({cur_req, " col"}, arr_col, m_rcol_req);
            end
            check({cur_req, " rcol"}, arr_rcol, m_col);
            check({cur_req, " wvalid"}, wr_valid, m_wv);
            if (m_wv != 0) begin
                check("R8 wdata", wr_data, m_wd);
                check("R8 widx", wr_idx, m_wi);
            end
        end
        if (arr_req && !prev_req) req_count++;
        if (wr_valid) wv_count++;
        prev_req = arr_req;
    end

    // ---------------- stimulus ----------------
    task automatic strobe(input logic c, input logic a, input logic [7:0] b);
        @(negedge clk); #2;
        cle = c; ale = a; io_din = b; io_wr = 1;
        @(negedge clk); #2;
        io_wr = 0; cle = 0; ale = 0;
    endtask
    task automatic send_cmd(input logic [7:0] b);  strobe(1, 0, b); endtask
    task automatic send_addr(input logic [7:0] b); strobe(0, 1, b); endtask
    task automatic send_data(input logic [7:0] b); strobe(0, 0, b); endtask
    task automatic do_read(output logic [7:0] v);
        @(negedge clk); #2;
        v = io_dout; io_rd = 1;
        @(negedge clk); #2;
        io_rd = 0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 20);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int rc;
        repeat (4) @(negedge clk);
        #2 rst = 0; ce_n = 0;
        idle(1);
        // R11 reset state
        cur_req = "R11";
        check("R11 reset dout", io_dout, 0);
        check("R11 reset req", arr_req, 0);
        check("R13 ready at reset", ready_busy, 1);

        // R6 read ID, R12 unknown opcode keeps ID mode
        cur_req = "R6";
        send_cmd(8'h90); send_addr(8'h00);
        do_read(v); check("R6 id0", v, 8'hEC);
        do_read(v); check("R6 id1", v, 8'h73);
        cur_req = "R12";
        send_cmd(8'h33);
        do_read(v); check("R12 id2 after unknown", v, 8'hA5);
        cur_req = "R6";
        do_read(v); check("R6 id3", v, 8'hC0);
        do_read(v); check("R6 id end", v, 8'h00);

        // R7 status sticky, bit7 follows wp_n
        cur_req = "R7";
        send_cmd(8'h70);
        do_read(v); check("R7 status", v, 8'hC0);
        do_read(v); check("R7 status sticky", v, 8'hC0);
        wp_n = 0;
        do_read(v); check("R7 status wp low", v, 8'h40);
        wp_n = 1;
        // R1 CE high ignores strobes and drives zero
        cur_req = "R1";
        ce_n = 1;
        idle(1); check("R1 dout ce high", io_dout, 0);
        send_cmd(8'h90);
        ce_n = 0;
        do_read(v); check("R1 ignored cmd", v, 8'hC0);

        // R4/R2/R5 plain read
        cur_req = "R4";
        send_cmd(8'h00); send_addr(8'h05); send_addr(8'h02); send_addr(8'h01);
        check("R4 op", arr_op, 1); check("R2 page", arr_page, 16'h0102);
        check("R4 col", arr_col, 5); check("R4 req", arr_req, 1);
        idle(6);
        cur_req = "R5";
        do_read(v); check("R5 byte0", v, 8'h07);
        do_read(v); check("R5 byte1", v, 8'h04);
        do_read(v); check("R5 byte2", v, 8'h05);

        // R3 offset 0x100
        cur_req = "R3";
        send_cmd(8'h01); send_addr(8'h10); send_addr(8'h00); send_addr(8'h00);
        check("R3 col 0x100", arr_col, 16'h110);
        idle(6);
        // R3/R5 spare area, end of page
        send_cmd(8'h50); send_addr(8'h0C); send_addr(8'h03); send_addr(8'h00);
        check("R3 col spare", arr_col, 524);
        idle(6);
        cur_req = "R5";
        do_read(v); check("R5 spare0", v, 8'h0F);
        do_read(v); check("R5 spare1", v, 8'h0E);
        do_read(v); check("R5 spare2", v, 8'h0D);
        do_read(v); check("R5 spare3", v, 8'h0C);
        do_read(v); check("R5 past end", v, 8'h00);
        // column beyond page
        send_cmd(8'h50); send_addr(8'hFF); send_addr(8'h00); send_addr(8'h00);
        idle(6);
        do_read(v); check("R5 start past end", v, 8'h00);

        // R12 unknown opcode keeps address count
        cur_req = "R12";
        send_cmd(8'h00); send_addr(8'h01); send_addr(8'h02);
        rc = req_count;
        send_cmd(8'h33); send_addr(8'h03);
        check("R12 load after unknown", req_count, rc + 1);
        check("R12 page", arr_page, 16'h0302);
        idle(6);

        // R8/R3 program with pending spare offset
        cur_req = "R8";
        send_cmd(8'h50); send_cmd(8'h80);
        send_addr(8'h04); send_addr(8'h07); send_addr(8'h05);
        send_data(8'hAA); send_data(8'hBB);
        send_cmd(8'h10);
        check("R8 prog op", arr_op, 2); check("R8 prog page", arr_page, 16'h0507);
        check("R3 prog col keeps offset", arr_col, 516);
        idle(6);
        send_cmd(8'h80); send_addr(8'h04); send_addr(8'h07); send_addr(8'h05);
        send_cmd(8'h10);
        check("R3 offset consumed", arr_col, 4);
        idle(6);

        // R9 erase with mask
        cur_req = "R9";
        send_cmd(8'h60); send_addr(8'h34); send_addr(8'h12); send_cmd(8'hD0);
        check("R9 erase op", arr_op, 3); check("R9 erase page", arr_page, 16'h1234);
        idle(6);
        send_cmd(8'h60); send_addr(8'h56); send_cmd(8'hD0);
        check("R9 erase one byte", arr_page, 16'h0056);
        idle(6);

        // R10 write protect
        cur_req = "R10";
        wp_n = 0; rc = req_count;
        send_cmd(8'h80); send_addr(8'h00); send_addr(8'h00); send_addr(8'h00); send_cmd(8'h10);
        send_cmd(8'h60); send_addr(8'h01); send_cmd(8'hD0);
        idle(6);
        check("R10 no request", req_count, rc);
        wp_n = 1;

        // R13 dropped while pending
        cur_req = "R13";
        rc = req_count;
        send_cmd(8'h60); send_addr(8'h01); send_addr(8'h00);
        send_cmd(8'hD0); send_cmd(8'hD0);
        idle(8);
        check("R13 single request", req_count, rc + 1);

        // R8 overflow
        cur_req = "R8";
        send_cmd(8'h80); send_addr(8'h00); send_addr(8'h00); send_addr(8'h00);
        rc = wv_count;
        for (int i = 0; i < 530; i++) send_data(8'(i));
        idle(2);
        check("R8 bytes kept", wv_count - rc, 528);

        // R11 reset opcode
        cur_req = "R11";
        send_cmd(8'h00); send_addr(8'h00); send_addr(8'h01); send_addr(8'h00);
        idle(6);
        do_read(v); check("R11 before reset", v, 8'h01);
        send_cmd(8'hFF);
        do_read(v); check("R11 after reset", v, 8'h00);

        idle(4);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule